// File: doc/BRIEF.md
# GPIO Port Bank with Set/Clear Register Aliases

This block is the register side of a general-purpose I/O bank built from ports of 16 pins each. Each port keeps four control registers: pin direction, output latch, input enable and Schmitt enable. The pin-facing signals are driven straight from these registers. The incoming pad levels pass through a two-flop synchronizer and are read back through a data address. Software changes selected bits atomically by writing a mask to a set alias or a clear alias, so it never needs a read-modify-write sequence.

The bus is a single-cycle register port. A write is accepted on the clock edge where the write enable is high. Read data is a combinational function of the address, with no wait states. There is no back-pressure in either direction, so the bus has no valid/ready pair. The pin-facing signals are plain levels.

Top module: `gpio_port_bank`

## Requirements
- R1: The word address is split into three fields. Bits [1:0] select the alias: 0 is the base register, 1 the set alias, 2 the clear alias and 3 is reserved. The next `PORT_W` bits select the port. The top 3 bits select the register kind: 0 direction, 1 output latch, 2 data, 3 input enable, 4 Schmitt enable, and 5 to 7 unused. Global pin n belongs to port n/16, bit n%16, and only that port's register is affected.
- R2: A write to the set alias ORs the written mask into the selected register. Mask bits that are zero leave their register bits unchanged.
- R3: A write to the clear alias clears every register bit whose mask bit is one. All other register bits keep their value.
- R4: A write to the base address loads the register with the written word. Writes to the reserved alias, to the data kind or to an unused kind change no register. With no write, every register holds its value.
- R5: Reading the set alias or the clear alias of a register returns the current value of that register.
- R6: `pad_oe` carries the direction bits, where 1 means the pin drives its output and 0 means input. `pad_out` carries the output latch.
- R7: A read of the data kind (alias 0, 1 or 2) returns, bit by bit, the output latch for pins whose direction is 1 and the synchronized pad level for pins whose direction is 0.
- R8: A pad level present at one rising edge becomes visible to data reads after the next rising edge, and not before that edge.
- R9: Reset clears direction, the output latch and Schmitt enable, and sets input enable on every pin.
- R10: The input-enable and Schmitt-enable registers follow the same base/set/clear scheme as the other registers and drive `pad_ie` and `pad_smt`.
- R11: A read of the reserved alias, of an unused kind or of a port index outside the bank returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address (kind, port, alias) |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 16 | Write word or bit mask |
| bus_rdata | output | 16 | Read word for bus_addr |
| pad_in | input | NUM_PORTS*16 | Raw pad input levels |
| pad_out | output | NUM_PORTS*16 | Output latch to pads |
| pad_oe | output | NUM_PORTS*16 | Output enable per pin (direction) |
| pad_ie | output | NUM_PORTS*16 | Input buffer enable per pin |
| pad_smt | output | NUM_PORTS*16 | Schmitt trigger enable per pin |

## Verification
The embedded properties check the following on every cycle. Each register slice ORs on a set write, clears on a clear write and holds when it is not written. The pin-facing outputs take their reset values after reset. The synchronized pad value always equals the pad level from two edges earlier.

Only the bench scenarios can show the remaining behaviour. These are the address decode to the right port and register, the alias read-back, the masking of ignored writes, the per-bit mixing of latch and pad on data reads, and the exact cycle in which a pad change first appears. The bench sweeps these across every port and register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS_PER_PORT = 16;
  localparam int NUM_CTRL      = 4;

  typedef enum logic [1:0] {
    AL_BASE = 2'd0,
    AL_SET  = 2'd1,
    AL_CLR  = 2'd2,
    AL_RSVD = 2'd3
  } alias_e;

  typedef enum logic [2:0] {
    RK_DIR  = 3'd0,
    RK_DOUT = 3'd1,
    RK_DATA = 3'd2,
    RK_IE   = 3'd3,
    RK_SMT  = 3'd4
  } kind_e;

  function automatic kind_e ctrl_kind(input int idx);
    case (idx)
      0:       return RK_DIR;
      1:       return RK_DOUT;
      2:       return RK_IE;
      default: return RK_SMT;
    endcase
  endfunction
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_pkg::*;
#(
  parameter int W        = 16,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_e       op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= {W{RST_ONES}};
    end else if (wr_en) begin
      case (op)
        AL_BASE: q <= wdata;
        AL_SET:  q <= q | wdata;
        AL_CLR:  q <= q & ~wdata;
        default: q <= q;
      endcase
    end
  end

  p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == AL_SET) |=> (q == ($past(q) | $past(wdata))));

  p_clr_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == AL_CLR) |=> (q == ($past(q) & ~$past(wdata))));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(q));
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  localparam int W      = PINS_PER_PORT,
  localparam int NPINS  = NUM_PORTS * W,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W = 3 + PORT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_ie,
  output logic [NPINS-1:0]  pad_smt
);
  alias_e            sel_alias;
  logic [2:0]        sel_kind;
  logic [PORT_W-1:0] sel_port;
  logic              port_ok;
  logic [PORT_W-1:0] port_idx;
  logic              wr_ok;

  assign sel_alias = alias_e'(bus_addr[1:0]);
  assign sel_port  = bus_addr[2 +: PORT_W];
  assign sel_kind  = bus_addr[ADDR_W-1 -: 3];
  assign port_ok   = ({1'b0, sel_port} < (PORT_W+1)'(NUM_PORTS));
  assign port_idx  = port_ok ? sel_port : '0;
  assign wr_ok     = bus_we && port_ok && (sel_alias != AL_RSVD);

  logic [W-1:0]     ctrl_q [NUM_PORTS][NUM_CTRL];
  logic [NPINS-1:0] pad_sync;

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    for (genvar gr = 0; gr < NUM_CTRL; gr++) begin : g_reg
      localparam kind_e K = ctrl_kind(gr);
      logic hit;
      assign hit = wr_ok && (sel_port == PORT_W'(gp)) && (sel_kind == K);

      gpio_alias_reg #(
        .W        (W),
        .RST_ONES (K == RK_IE)
      ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (hit),
        .op    (sel_alias),
        .wdata (bus_wdata),
        .q     (ctrl_q[gp][gr])
      );
    end

    assign pad_oe [gp*W +: W] = ctrl_q[gp][0];
    assign pad_out[gp*W +: W] = ctrl_q[gp][1];
    assign pad_ie [gp*W +: W] = ctrl_q[gp][2];
    assign pad_smt[gp*W +: W] = ctrl_q[gp][3];
  end

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  always_comb begin
    logic [W-1:0] dir_w;
    logic [W-1:0] lat_w;
    logic [W-1:0] pin_w;
    dir_w     = ctrl_q[port_idx][0];
    lat_w     = ctrl_q[port_idx][1];
    pin_w     = pad_sync[port_idx*W +: W];
    bus_rdata = '0;
    if (port_ok && sel_alias != AL_RSVD) begin
      case (sel_kind)
        RK_DIR:  bus_rdata = dir_w;
        RK_DOUT: bus_rdata = lat_w;
        RK_DATA: bus_rdata = (dir_w & lat_w) | (~dir_w & pin_w);
        RK_IE:   bus_rdata = ctrl_q[port_idx][2];
        RK_SMT:  bus_rdata = ctrl_q[port_idx][3];
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (pad_sync == $past(pad_in, 2)));

  p_rst_vals_r9: assert property (@(posedge clk)
    (!rst_n) |=> (pad_oe == '0 && pad_out == '0 && pad_ie == '1 && pad_smt == '0));
endmodule

// File: tb/gpio_port_bank_tb.sv
module gpio_port_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int W  = 16;
  localparam int PW = 1;
  localparam int AW = 3 + PW + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [W-1:0]    bus_wdata = '0;
  logic [W-1:0]    bus_rdata;
  logic [NP*W-1:0] pad_in = '0;
  logic [NP*W-1:0] pad_out, pad_oe, pad_ie, pad_smt;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [W-1:0] mdl [4][NP];
  logic [W-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_bank #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_smt(pad_smt)
  );

  function automatic logic [AW-1:0] mk(input int kind, input int port, input int al);
    return {kind[2:0], port[PW-1:0], al[1:0]};
  endfunction

  function automatic int kind_of(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int p = 0; p < NP; p++) begin
      mdl[0][p] = '0; mdl[1][p] = '0; mdl[2][p] = '1; mdl[3][p] = '0;
    end
  endtask

  task automatic wr(input int kind, input int port, input int al, input logic [W-1:0] d);
    int idx;
    @(negedge clk);
    bus_addr = mk(kind, port, al); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (kind)
      0: idx = 0; 1: idx = 1; 3: idx = 2; 4: idx = 3; default: idx = -1;
    endcase
    if (idx >= 0 && port < NP) begin
      case (al)
        0: mdl[idx][port] = d;
        1: mdl[idx][port] = mdl[idx][port] | d;
        2: mdl[idx][port] = mdl[idx][port] & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input int kind, input int port, input int al, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = mk(kind, port, al);
    #1 d = bus_rdata;
  endtask

  task automatic check_one(input int idx, input int p, input string req);
    logic [W-1:0] v;
    rd(kind_of(idx), p, 0, v); check(req, v, mdl[idx][p]);
    rd(kind_of(idx), p, 1, v); check("R5 set-alias read", v, mdl[idx][p]);
    rd(kind_of(idx), p, 2, v); check("R5 clear-alias read", v, mdl[idx][p]);
    rd(kind_of(idx), p, 3, v); check("R11 reserved alias", v, '0);
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) begin
      for (int idx = 0; idx < 4; idx++) check_one(idx, p, req);
      check("R6 pad_oe", pad_oe[p*W +: W], mdl[0][p]);
      check("R6 pad_out", pad_out[p*W +: W], mdl[1][p]);
      check("R10 pad_ie", pad_ie[p*W +: W], mdl[2][p]);
      check("R10 pad_smt", pad_smt[p*W +: W], mdl[3][p]);
    end
  endtask

  function automatic logic [W-1:0] exp_data(input int p);
    return (mdl[0][p] & mdl[1][p]) | (~mdl[0][p] & pad_in[p*W +: W]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R9 reset value");

    // R2 R3 R4 R10: sweep each port and register with base, set and clear writes
    for (int p = 0; p < NP; p++) begin
      for (int idx = 0; idx < 4; idx++) begin
        for (int i = 0; i < 16; i++) begin
          logic [W-1:0] pat;
          pat = 16'h5A3C ^ W'(i * 16'h1357);
          wr(kind_of(idx), p, 0, pat);
          check_one(idx, p, (idx >= 2) ? "R10 base load" : "R4 base load");
          wr(kind_of(idx), p, 1, W'(1) << i);
          check_one(idx, p, "R2 set alias");
          wr(kind_of(idx), p, 2, (16'h8421 << (i % 4)) | (W'(1) << ((i + 5) % 16)));
          check_one(idx, p, "R3 clear alias");
          wr(kind_of(idx), p, 1, ~pat);
          check_one(idx, p, "R2 multi-bit set");
        end
      end
    end
    check_all("R1 port decode");

    // R1: distinct per-port values, other port untouched
    wr(1, 0, 0, 16'hC0DE); wr(1, 1, 0, 16'h0BAD);
    wr(1, 1, 1, 16'h0001);
    check_all("R1 port isolation");

    // R4: ignored writes
    wr(2, 0, 0, 16'hFFFF); wr(2, 1, 1, 16'hFFFF);
    wr(0, 0, 3, 16'hFFFF); wr(3, 1, 3, 16'h0000);
    wr(5, 0, 0, 16'hFFFF); wr(7, 1, 2, 16'hFFFF);
    check_all("R4 ignored write");
    for (int k = 5; k < 8; k++) begin
      rd(k, 0, 0, rv); check("R11 unused kind", rv, '0);
    end

    // R7: mixed direction data read
    wr(0, 0, 0, 16'hFF00); wr(1, 0, 0, 16'h1234);
    wr(0, 1, 0, 16'h0F0F); wr(1, 1, 0, 16'hBEEF);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      pad_in = {16'h3C5A ^ W'(j * 16'h2111), 16'hA55A ^ W'(j * 16'h1F0F)};
      repeat (3) @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        for (int al = 0; al < 3; al++) begin
          rd(2, p, al, rv); check("R7 data read", rv, exp_data(p));
        end
      end
    end

    // R8: synchronizer latency
    wr(0, 0, 0, 16'h0000);
    @(negedge clk); pad_in[15:0] = 16'h1111;
    repeat (3) @(negedge clk);
    @(negedge clk); pad_in[15:0] = 16'hEEEE;
    rd(2, 0, 0, rv); check("R8 before second edge", rv, 16'h1111);
    rd(2, 0, 0, rv); check("R8 after second edge", rv, 16'hEEEE);

    // R9: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reset_model();
    check_all("R9 mid-run reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule